// File: doc/BRIEF.md
# Multi-width integer multiplier

This unit is the multiply execution stage of a 32-bit integer datapath. It takes two operands, an operand size (byte, word or long), a signed/unsigned choice and an instruction form, and returns a product together with an overflow flag and a carry flag. The unit supports three forms. The widening form returns the full double-width product, split into a high half and a low half. The two-operand form and the immediate form are always signed and keep only a destination-width result.

A request is offered with `start` while `ready` is high. The controller steps through three named states. In `ST_IDLE` the unit waits and shows `ready`. Transition IDLE->EXEC is taken when `start` is seen, and the extended operands are captured on that edge. In `ST_EXEC` the registered operands are multiplied and the packed result and flags are written into output registers. Transition EXEC->RESP is taken unconditionally. In `ST_RESP` the unit raises `done` for that single cycle. Transition RESP->IDLE is unconditional. The outputs keep the last result until the next `done`.

Top module: `mwmul_top`

## Requirements
- R1: After reset `ready` is 1, `done` is 0, and `prod_hi`, `prod_lo`, `ovf_flag` and `carry_flag` are all 0.
- R2: A `start` sampled while `ready` is 1 is accepted. `ready` is 0 for the next two cycles, and `done` is 1 for exactly one cycle, two clock edges after the accepting edge. A `start` that arrives while `ready` is 0 is ignored.
- R3: `size_sel` encoding is 00 = byte (8 bits), 01 = word (16 bits), 10 = long (32 bits), and 11 = long (the default). Operand bits above the selected width have no effect on any output.
- R4: In the widening form (`form_sel` = 00) with `signed_sel` = 0, the zero-extended operands are multiplied. `prod_lo` holds the low W product bits and `prod_hi` holds the next W bits, where W is the width selected by `size_sel`. Both are zero-extended to 32 bits.
- R5: In the widening form with `signed_sel` = 1, the sign-extended operands are multiplied, and the two W-bit halves of the 2W-bit product are returned as described in R4.
- R6: In the widening unsigned case, the flags are 1 exactly when the high half of the product is nonzero.
- R7: In the widening signed case, the flags are 0 exactly when the 2W-bit product equals the sign extension of its low W bits.
- R8: The two-operand form (`form_sel` = 01, and code 11 behaves the same way) and the immediate form (`form_sel` = 10) are signed whatever the value of `signed_sel`. `prod_lo` holds the low W product bits and `prod_hi` is 0. In these forms a byte size runs at word width.
- R9: In the truncating forms, the flags are 1 exactly when the exact signed product lies outside the signed W-bit range.
- R10: In the immediate form with `imm_short` = 1, the second operand is the low 8 bits of `opnd_b`, sign-extended. Otherwise its low W bits are sign-extended. `imm_short` has no effect in the other forms.
- R11: `ovf_flag` and `carry_flag` always carry the same value.
- R12: `prod_hi`, `prod_lo` and the flags change only on the cycle in which `done` is 1, and they hold that value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe |
| ready | output | 1 | Unit idle, can accept a request |
| opnd_a | input | 32 | First operand (accumulator side) |
| opnd_b | input | 32 | Second operand or immediate |
| size_sel | input | 2 | Operand width code |
| form_sel | input | 2 | 00 widening, 01/11 two-operand, 10 immediate |
| signed_sel | input | 1 | Signed multiply in the widening form |
| imm_short | input | 1 | Immediate is 8 bits, sign-extended |
| done | output | 1 | One-cycle result strobe |
| prod_hi | output | 32 | High half (widening form) or zero |
| prod_lo | output | 32 | Low half or truncated result |
| ovf_flag | output | 1 | Overflow flag |
| carry_flag | output | 1 | Carry flag |

## Verification
Directed cases set byte, word and long operands to the most negative value, to all ones and to small values. These cases separate the signed and unsigned extension paths and show whether each flag rule uses the right half. Operands that carry junk above the selected width show whether the width masking is correct. Requests with an 8-bit immediate and with a full-width immediate separate the two immediate paths. Several hundred random requests across every size, form and signedness are compared on every clock with a behavioural model, and a `start` held high while the unit is busy checks that the unit ignores it.

// File: rtl/mwmul_pkg.sv
package mwmul_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_DFLT = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        FM_WIDE = 2'b00,
        FM_TWO  = 2'b01,
        FM_IMM  = 2'b10,
        FM_ALT  = 2'b11
    } form_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_EXEC = 2'b01,
        ST_RESP = 2'b10
    } state_e;

    // effective width codes after form promotion
    localparam logic [1:0] WC_BYTE = 2'd0;
    localparam logic [1:0] WC_HALF = 2'd1;
    localparam logic [1:0] WC_FULL = 2'd2;
endpackage

// File: rtl/mwmul_ctrl.sv
module mwmul_ctrl
    import mwmul_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready,
    output logic load,
    output logic fire,
    output logic done
);
    state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready = (state_q == ST_IDLE);
        load  = ready && start;
        fire  = (state_q == ST_EXEC);
        done  = (state_q == ST_RESP);
    end
endmodule

// File: rtl/mwmul_opsel.sv
module mwmul_opsel
    import mwmul_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [1:0]        size_sel,
    input  logic [1:0]        form_sel,
    input  logic              signed_sel,
    input  logic              imm_short,
    output logic [DATA_W:0]   a_ext,
    output logic [DATA_W:0]   b_ext,
    output logic [1:0]        wcode,
    output logic              wide,
    output logic              sgn
);
    localparam int unsigned BW = DATA_W / 4;
    localparam int unsigned HW = DATA_W / 2;

    function automatic logic [DATA_W:0] extend(input logic [DATA_W-1:0] v,
                                               input logic [1:0] wc,
                                               input logic s);
        logic [DATA_W:0] r;
        unique case (wc)
            WC_BYTE: r = {{(DATA_W-BW+1){s & v[BW-1]}}, v[BW-1:0]};
            WC_HALF: r = {{(DATA_W-HW+1){s & v[HW-1]}}, v[HW-1:0]};
            default: r = {s & v[DATA_W-1], v};
        endcase
        return r;
    endfunction

    always_comb begin
        wide = (form_e'(form_sel) == FM_WIDE);
        sgn  = !wide || signed_sel;
        unique case (size_e'(size_sel))
            SZ_BYTE: wcode = wide ? WC_BYTE : WC_HALF;
            SZ_WORD: wcode = WC_HALF;
            default: wcode = WC_FULL;
        endcase
        a_ext = extend(opnd_a, wcode, sgn);
        if (form_e'(form_sel) == FM_IMM && imm_short)
            b_ext = extend(opnd_b, WC_BYTE, 1'b1);
        else
            b_ext = extend(opnd_b, wcode, sgn);
    end
endmodule

// File: rtl/mwmul_core.sv
module mwmul_core #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W:0]     a_ext,
    input  logic [DATA_W:0]     b_ext,
    output logic [2*DATA_W+1:0] prod
);
    always_comb prod = $signed(a_ext) * $signed(b_ext);
endmodule

// File: rtl/mwmul_pack.sv
module mwmul_pack
    import mwmul_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [2*DATA_W+1:0] prod,
    input  logic [1:0]          wcode,
    input  logic                wide,
    input  logic                sgn,
    output logic [DATA_W-1:0]   hi,
    output logic [DATA_W-1:0]   lo,
    output logic                flag
);
    localparam int unsigned BW = DATA_W / 4;
    localparam int unsigned HW = DATA_W / 2;

    logic [DATA_W-1:0] hi_raw;
    logic              hi_nz;
    logic              hi_not_fill;

    always_comb begin
        unique case (wcode)
            WC_BYTE: begin
                lo          = {{(DATA_W-BW){1'b0}}, prod[BW-1:0]};
                hi_raw      = {{(DATA_W-BW){1'b0}}, prod[2*BW-1:BW]};
                hi_nz       = |prod[2*BW-1:BW];
                hi_not_fill = prod[2*BW-1:BW] != {BW{prod[BW-1]}};
            end
            WC_HALF: begin
                lo          = {{(DATA_W-HW){1'b0}}, prod[HW-1:0]};
                hi_raw      = {{(DATA_W-HW){1'b0}}, prod[2*HW-1:HW]};
                hi_nz       = |prod[2*HW-1:HW];
                hi_not_fill = prod[2*HW-1:HW] != {HW{prod[HW-1]}};
            end
            default: begin
                lo          = prod[DATA_W-1:0];
                hi_raw      = prod[2*DATA_W-1:DATA_W];
                hi_nz       = |prod[2*DATA_W+1:DATA_W];
                hi_not_fill = prod[2*DATA_W+1:DATA_W] != {(DATA_W+2){prod[DATA_W-1]}};
            end
        endcase
        hi   = wide ? hi_raw : '0;
        flag = (wide && !sgn) ? hi_nz : hi_not_fill;
    end
endmodule

// File: rtl/mwmul_top.sv
module mwmul_top
    import mwmul_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              ready,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [1:0]        size_sel,
    input  logic [1:0]        form_sel,
    input  logic              signed_sel,
    input  logic              imm_short,
    output logic              done,
    output logic [DATA_W-1:0] prod_hi,
    output logic [DATA_W-1:0] prod_lo,
    output logic              ovf_flag,
    output logic              carry_flag
);
    logic              load, fire;
    logic [DATA_W:0]   a_ext, b_ext, a_q, b_q;
    logic [1:0]        wcode, wcode_q;
    logic              wide, sgn, wide_q, sgn_q;
    logic [2*DATA_W+1:0] prod;
    logic [DATA_W-1:0] hi_d, lo_d;
    logic              flag_d;

    mwmul_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ready (ready),
        .load  (load),
        .fire  (fire),
        .done  (done)
    );

    mwmul_opsel #(.DATA_W(DATA_W)) u_opsel (
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .size_sel   (size_sel),
        .form_sel   (form_sel),
        .signed_sel (signed_sel),
        .imm_short  (imm_short),
        .a_ext      (a_ext),
        .b_ext      (b_ext),
        .wcode      (wcode),
        .wide       (wide),
        .sgn        (sgn)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            wcode_q <= WC_FULL;
            wide_q  <= 1'b1;
            sgn_q   <= 1'b0;
        end else if (load) begin
            a_q     <= a_ext;
            b_q     <= b_ext;
            wcode_q <= wcode;
            wide_q  <= wide;
            sgn_q   <= sgn;
        end
    end

    mwmul_core #(.DATA_W(DATA_W)) u_core (
        .a_ext (a_q),
        .b_ext (b_q),
        .prod  (prod)
    );

    mwmul_pack #(.DATA_W(DATA_W)) u_pack (
        .prod  (prod),
        .wcode (wcode_q),
        .wide  (wide_q),
        .sgn   (sgn_q),
        .hi    (hi_d),
        .lo    (lo_d),
        .flag  (flag_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_hi    <= '0;
            prod_lo    <= '0;
            ovf_flag   <= 1'b0;
            carry_flag <= 1'b0;
        end else if (fire) begin
            prod_hi    <= hi_d;
            prod_lo    <= lo_d;
            ovf_flag   <= flag_d;
            carry_flag <= flag_d;
        end
    end
endmodule

// File: rtl/mwmul_chk.sv
module mwmul_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ready,
    input logic [1:0]        size_sel,
    input logic [1:0]        form_sel,
    input logic              signed_sel,
    input logic              done,
    input logic [DATA_W-1:0] prod_hi,
    input logic [DATA_W-1:0] prod_lo,
    input logic              ovf_flag
);
    localparam int unsigned BW = DATA_W / 4;

    // R2: result strobe two edges after acceptance
    a_r2_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |-> ##2 done);

    // R2: strobe lasts one cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: busy after acceptance
    a_r2_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready);

    // R12: outputs stay put between strobes
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(prod_hi) && $stable(prod_lo) && $stable(ovf_flag)));

    // R8: truncating forms give zero high half
    a_r8_trunc_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready && form_sel != 2'b00) |-> ##2 (prod_hi == '0));

    // R6: unsigned byte widening flag follows the high byte
    a_r6_byte_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready && form_sel == 2'b00 && !signed_sel && size_sel == 2'b00)
        |-> ##2 (prod_hi[DATA_W-1:BW] == '0 && prod_lo[DATA_W-1:BW] == '0
                 && ovf_flag == (prod_hi[BW-1:0] != '0)));
endmodule

bind mwmul_top mwmul_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mwmul_top_tb.sv
module mwmul_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ready;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [1:0]  size_sel = '0, form_sel = '0;
    logic        signed_sel = 1'b0, imm_short = 1'b0;
    logic        done;
    logic [31:0] prod_hi, prod_lo;
    logic        ovf_flag, carry_flag;

    int checks = 0;
    int fails  = 0;

    mwmul_top u_dut (.*);

    always #10 clk = ~clk;

    function automatic longint sx(longint v, int w);
        return (v <<< (64 - w)) >>> (64 - w);
    endfunction

    task automatic model(input logic [31:0] a, b, input logic [1:0] sz, fm,
                         input logic sg, im8,
                         output logic [31:0] eh, el, output logic ef);
        int w; longint av, bv, p, m; logic s;
        w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        if (fm != 2'd0 && w == 8) w = 16;
        s = (fm != 2'd0) || sg;
        m = (w == 32) ? 64'hFFFF_FFFF : ((64'd1 << w) - 1);
        av = s ? sx(longint'(a), w) : (longint'(a) & m);
        if (fm == 2'd2 && im8) bv = sx(longint'(b), 8);
        else bv = s ? sx(longint'(b), w) : (longint'(b) & m);
        p  = av * bv;
        el = 32'(p & m);
        if (fm == 2'd0) begin
            eh = 32'((p >> w) & m);
            ef = s ? (p != sx(p, w)) : (((p >> w) & m) != 0);
        end else begin
            eh = '0;
            ef = (p != sx(p, w));
        end
    endtask

    // reference pipeline and expectation queues
    logic [31:0] q_h[$], q_l[$];
    logic        q_f[$];
    string       q_tag[$], q_ftag[$];
    logic        d0 = 1'b0, d1 = 1'b0;
    logic [31:0] cur_h = '0, cur_l = '0;
    logic        cur_f = 1'b0;

    task automatic fail_line(string tag, string what, longint act, longint exp);
        fails++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            logic exp_ready; logic [31:0] eh, el; logic ef;
            exp_ready = !(d0 || d1);
            checks++;
            if (ready !== exp_ready) fail_line("R2", "ready", ready, exp_ready);
            checks++;
            if (done !== d1) fail_line("R2", "done", done, d1);
            if (d1) begin
                cur_h = q_h.pop_front(); cur_l = q_l.pop_front(); cur_f = q_f.pop_front();
                checks++;
                if (prod_hi !== cur_h || prod_lo !== cur_l) begin
                    fail_line(q_tag[0], "hi", prod_hi, cur_h);
                    fail_line(q_tag[0], "lo", prod_lo, cur_l);
                    fails--;
                end
                checks++;
                if (ovf_flag !== cur_f) fail_line(q_ftag[0], "ovf", ovf_flag, cur_f);
                checks++;
                if (carry_flag !== ovf_flag) fail_line("R11", "carry", carry_flag, ovf_flag);
                void'(q_tag.pop_front()); void'(q_ftag.pop_front());
            end else begin
                checks++;
                if (prod_hi !== cur_h || prod_lo !== cur_l || ovf_flag !== cur_f
                    || carry_flag !== cur_f)
                    fail_line("R12", "held lo", prod_lo, cur_l);
            end
            d1 = d0;
            d0 = start && exp_ready;
            if (d0) begin
                model(opnd_a, opnd_b, size_sel, form_sel, signed_sel, imm_short, eh, el, ef);
                q_h.push_back(eh); q_l.push_back(el); q_f.push_back(ef);
                if (form_sel == 2'd0) begin
                    q_tag.push_back(signed_sel ? "R5" : "R4");
                    q_ftag.push_back(signed_sel ? "R7" : "R6");
                end else begin
                    q_tag.push_back(form_sel == 2'd2 ? "R10" : "R8");
                    q_ftag.push_back("R9");
                end
            end
        end
    end

    task automatic op(input logic [31:0] a, b, input logic [1:0] sz, fm,
                      input logic sg, im8);
        @(posedge clk); #2;
        while (!ready) begin @(posedge clk); #2; end
        opnd_a = a; opnd_b = b; size_sel = sz; form_sel = fm;
        signed_sel = sg; imm_short = im8; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        opnd_a = 32'hDEAD_BEEF; opnd_b = 32'h1234_5678;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] mn [3];
        mn[0] = 32'h80; mn[1] = 32'h8000; mn[2] = 32'h8000_0000;
        repeat (3) @(posedge clk);
        #5;
        // R1: reset values
        checks++;
        if (ready !== 1'b1 || done !== 1'b0 || prod_hi !== '0 || prod_lo !== '0
            || ovf_flag !== 1'b0 || carry_flag !== 1'b0)
            fail_line("R1", "reset", {ready, done, ovf_flag, carry_flag}, 4'b1000);
        rst_n = 1'b1;
        // R4/R6: unsigned byte, flag set and clear
        op(32'hFF, 32'hFF, 2'd0, 2'd0, 1'b0, 1'b0);
        op(32'h0F, 32'h0F, 2'd0, 2'd0, 1'b0, 1'b0);
        // R3: junk above the byte ignored
        op(32'hABCD_EF0F, 32'h5555_550F, 2'd0, 2'd0, 1'b0, 1'b0);
        // R5/R7: signed byte
        op(32'h80, 32'h80, 2'd0, 2'd0, 1'b1, 1'b0);
        op(32'hFF, 32'h05, 2'd0, 2'd0, 1'b1, 1'b0);
        // R3: default size code acts as long
        op(32'h8000_0000, 32'h8000_0000, 2'd3, 2'd0, 1'b1, 1'b0);
        op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, 2'd0, 1'b0, 1'b0);
        // R8/R9: truncating word and long
        op(32'h8000, 32'hFFFF, 2'd1, 2'd1, 1'b0, 1'b0);
        op(32'h0100, 32'h007F, 2'd1, 2'd1, 1'b0, 1'b0);
        op(32'h8000_0000, 32'h1, 2'd2, 2'd3, 1'b0, 1'b0);
        op(32'h0000_0010, 32'h0000_0042, 2'd0, 2'd1, 1'b0, 1'b0);
        // R10: short and full immediate
        op(32'h0000_1000, 32'h0000_00FE, 2'd2, 2'd2, 1'b0, 1'b1);
        op(32'h0000_1000, 32'h0000_00FE, 2'd2, 2'd2, 1'b0, 1'b0);
        op(32'h0000_7FFF, 32'hFFFF_FF82, 2'd1, 2'd2, 1'b0, 1'b1);
        // R10: imm_short ignored outside the immediate form
        op(32'h0000_1000, 32'h0000_00FE, 2'd2, 2'd1, 1'b0, 1'b1);
        // R2: start held while busy, only the first is taken
        @(posedge clk); #2;
        while (!ready) begin @(posedge clk); #2; end
        opnd_a = 32'd3; opnd_b = 32'd7; size_sel = 2'd2; form_sel = 2'd0;
        signed_sel = 1'b0; imm_short = 1'b0; start = 1'b1;
        @(posedge clk); #2; opnd_a = 32'd9;
        @(posedge clk); #2; opnd_a = 32'd11;
        @(posedge clk); #2; start = 1'b0;
        // most negative operands at every size and form
        for (int s = 0; s < 3; s++)
            for (int f = 0; f < 3; f++)
                for (int g = 0; g < 2; g++) begin
                    op(mn[s], mn[s], 2'(s), 2'(f), 1'(g), 1'b0);
                    op(mn[s], 32'hFFFF_FFFF, 2'(s), 2'(f), 1'(g), 1'b0);
                end
        for (int i = 0; i < 500; i++)
            op($urandom, $urandom, 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
        repeat (6) @(posedge clk);
        finish_run();
    end
endmodule